// File: doc/BRIEF.md
# Reference Pulse Frequency Toggle Checker

This block confirms that a periodic reference pulse runs at the intended power-of-two ratio to a local timestamp clock. Upstream logic latches the timestamp counter's low bits on every rising edge of the pulse and presents them as an 8-bit phase word. When the pulse runs at the right rate, the low log2(ratio) bits of that word stay constant from pulse to pulse, while every higher bit eventually changes.

A test starts with a single-cycle strobe. The checker takes one initial reading of the phase word. It then takes a fixed number of further readings, spaced by a programmable number of clock cycles. Each reading is XORed with the initial one, and the result is ORed into a toggle mask. Once the last reading has been taken, the mask must equal all-ones with the low log2(ratio) bits cleared, and any difference means the test fails. If the sample-and-hold error flag is high when a reading is due, the test stops at once and reports an error.

The verdict and the mask stay on the outputs until the next accepted start.

Top module: `refpulse_freq_checker`

## Requirements
- R1: While rst_ni is low, and after it is released, busy_o, done_o, pass_o and err_o are 0 and mask_o is 0.
- R2: A start_i seen at a clock edge while busy_o is 0 is accepted. After that edge, busy_o is 1 and done_o, pass_o, err_o and mask_o are 0. The same edge latches ratio_log2_i and interval_i, with an interval of 0 treated as 1.
- R3: The initial phase reading is taken at the first edge after acceptance. Sample reading n (n = 1..NUM_SAMPLES) is taken at the edge that comes n times the latched interval later.
- R4: After each sample reading, mask_o equals its previous value ORed with (phase_i XOR initial reading). While busy_o is 1, mask_o never loses a set bit.
- R5: After the edge of the last sample, busy_o is 0 and done_o is 1. pass_o is 1 exactly when mask_o equals 8'hFF shifted left by the latched ratio_log2, keeping the low 8 bits, where the ratio is 2 to that power.
- R6: If sh_err_i is 1 at the edge where any reading is due, the test ends at that edge. done_o and err_o become 1, pass_o is 0, and mask_o keeps its value from before that reading.
- R7: Once done_o is 1, done_o, pass_o, err_o and mask_o hold their values until a start is accepted.
- R8: A start_i that arrives while busy_o is 1 is ignored. It does not restart the test or change the latched ratio or interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| phase_i | input | PHASE_W | Captured timestamp phase of the reference pulse |
| sh_err_i | input | 1 | Sample-and-hold timing error flag |
| ratio_log2_i | input | RATIO_W | log2 of the timestamp-to-pulse frequency ratio |
| interval_i | input | INT_W | Clock cycles between readings (0 acts as 1) |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | Test finished; the verdict is valid |
| pass_o | output | 1 | Toggle mask matched the expected pattern |
| err_o | output | 1 | Test aborted on a sample-and-hold error |
| mask_o | output | PHASE_W | Accumulated toggle mask |

## Verification
The hardest case to reach is a sample-and-hold error that arrives exactly at a sample edge in the middle of a run. The flag only matters on the cycles where a reading is due, so a short pulse can fall between readings and have no effect. The bench therefore holds the flag high for a full interval, which makes sure one reading edge sees it. A cycle-accurate behavioural model tracks the abort edge and the mask that is kept.

Mismatched ratios come from forcing the phase word's low bits stable over too few or too many bits. This gives both a mask that is too wide and a mask that is too narrow.

// File: rtl/refpulse_chk_pkg.sv
package refpulse_chk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_RUN  = 2'd2
  } chk_state_e;
endpackage

// File: rtl/refpulse_tick_gen.sv
module refpulse_tick_gen #(
  parameter int INT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic [INT_W-1:0] interval_i,
  output logic             tick_o
);
  logic [INT_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == interval_i - INT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (en_i)    cnt_q <= tick_o ? '0 : cnt_q + INT_W'(1);
  end
endmodule

// File: rtl/refpulse_sample_ctr.sv
module refpulse_sample_ctr #(
  parameter int NUM_SAMPLES = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CNT_W = $clog2(NUM_SAMPLES + 1);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = (cnt_q == CNT_W'(NUM_SAMPLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/refpulse_toggle_acc.sv
module refpulse_toggle_acc #(
  parameter int PHASE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               load_init_i,
  input  logic               acc_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic [PHASE_W-1:0] mask_o,
  output logic [PHASE_W-1:0] mask_next_o
);
  logic [PHASE_W-1:0] init_q;
  logic [PHASE_W-1:0] mask_q;

  assign mask_next_o = mask_q | (phase_i ^ init_q);
  assign mask_o      = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= '0;
      mask_q <= '0;
    end else begin
      if (load_init_i) init_q <= phase_i;
      if (clear_i)     mask_q <= '0;
      else if (acc_i)  mask_q <= mask_next_o;
    end
  end
endmodule

// File: rtl/refpulse_freq_checker.sv
module refpulse_freq_checker
  import refpulse_chk_pkg::*;
#(
  parameter int PHASE_W     = 8,
  parameter int RATIO_W     = 4,
  parameter int INT_W       = 16,
  parameter int NUM_SAMPLES = 20000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               sh_err_i,
  input  logic [RATIO_W-1:0] ratio_log2_i,
  input  logic [INT_W-1:0]   interval_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               pass_o,
  output logic               err_o,
  output logic [PHASE_W-1:0] mask_o
);
  localparam logic [PHASE_W-1:0] ALL_ONES = '1;

  chk_state_e         st_q;
  logic [RATIO_W-1:0] ratio_q;
  logic [INT_W-1:0]   int_q;
  logic               busy_q, done_q, pass_q, err_q;
  logic               accept, load_init, tick, take, last;
  logic [PHASE_W-1:0] mask_next, exp_mask;

  assign accept    = (st_q == ST_IDLE) && start_i;
  assign load_init = (st_q == ST_INIT) && !sh_err_i;
  assign take      = tick && !sh_err_i;
  assign exp_mask  = ALL_ONES << ratio_q;

  refpulse_tick_gen #(.INT_W(INT_W)) u_tick (
    .clk_i, .rst_ni,
    .clear_i   (load_init),
    .en_i      (st_q == ST_RUN),
    .interval_i(int_q),
    .tick_o    (tick)
  );

  refpulse_sample_ctr #(.NUM_SAMPLES(NUM_SAMPLES)) u_cnt (
    .clk_i, .rst_ni,
    .clear_i(load_init),
    .inc_i  (take),
    .last_o (last)
  );

  refpulse_toggle_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk_i, .rst_ni,
    .clear_i    (accept),
    .load_init_i(load_init),
    .acc_i      (take),
    .phase_i,
    .mask_o,
    .mask_next_o(mask_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ratio_q <= '0;
      int_q   <= INT_W'(1);
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q    <= ST_INIT;
          ratio_q <= ratio_log2_i;
          int_q   <= (interval_i == '0) ? INT_W'(1) : interval_i;
          busy_q  <= 1'b1;
          done_q  <= 1'b0;
          pass_q  <= 1'b0;
          err_q   <= 1'b0;
        end
        ST_INIT: begin
          if (sh_err_i) begin
            st_q   <= ST_IDLE;
            busy_q <= 1'b0;
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            st_q <= ST_RUN;
          end
        end
        ST_RUN: if (tick) begin
          if (sh_err_i) begin
            st_q   <= ST_IDLE;
            busy_q <= 1'b0;
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else if (last) begin
            st_q   <= ST_IDLE;
            busy_q <= 1'b0;
            done_q <= 1'b1;
            pass_q <= (mask_next == exp_mask);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign pass_o = pass_q;
  assign err_o  = err_q;
endmodule

// File: rtl/refpulse_freq_checker_sva.sv
module refpulse_freq_checker_sva #(
  parameter int PHASE_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic               pass_o,
  input logic               err_o,
  input logic [PHASE_W-1:0] mask_o
);
  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && !done_o && !pass_o && !err_o && mask_o == '0));

  a_r4_mask_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ((mask_o & $past(mask_o)) == $past(mask_o)));

  a_r5_pass_means_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> (done_o && !err_o && !busy_o));

  a_r6_err_no_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && !pass_o));

  a_r7_verdict_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(pass_o) && $stable(err_o) && $stable(mask_o)));

  a_r8_busy_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ((mask_o & $past(mask_o)) == $past(mask_o)));
endmodule

bind refpulse_freq_checker refpulse_freq_checker_sva #(.PHASE_W(PHASE_W)) u_sva (
  .clk_i, .rst_ni, .start_i, .busy_o, .done_o, .pass_o, .err_o, .mask_o
);

// File: tb/refpulse_freq_checker_test.sv
module refpulse_freq_checker_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] phase = 8'h00;
  logic       sh_err = 1'b0;
  logic [3:0] ratio = 4'd0;
  logic [15:0] intv = 16'd1;
  logic       busy, done, pass, err;
  logic [7:0] mask;

  int n_cmp = 0;
  int n_bad = 0;

  // stimulus shaping for phase: bits in smask forced to sval
  logic [7:0] smask = 8'h00;
  logic [7:0] sval  = 8'h00;
  logic [7:0] cyc   = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  refpulse_freq_checker #(.NUM_SAMPLES(NS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .phase_i(phase),
    .sh_err_i(sh_err), .ratio_log2_i(ratio), .interval_i(intv),
    .busy_o(busy), .done_o(done), .pass_o(pass), .err_o(err), .mask_o(mask)
  );

  always @(negedge clk) begin
    cyc   <= cyc + 8'd1;
    phase <= ((cyc * 8'h35 + 8'h11) & ~smask) | (sval & smask);
  end

  // behavioural reference model
  int         m_st;
  bit         m_busy, m_done, m_pass, m_err;
  logic [7:0] m_mask, m_init;
  int         m_k, m_int, m_wait, m_n;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_busy = 0; m_done = 0; m_pass = 0; m_err = 0;
      m_mask = 0; m_init = 0; m_k = 0; m_int = 1; m_wait = 0; m_n = 0;
    end else if (m_st == 0) begin
      if (start) begin
        m_st = 1; m_busy = 1; m_done = 0; m_pass = 0; m_err = 0; m_mask = 0;
        m_k = int'(ratio); m_int = (intv == 0) ? 1 : int'(intv);
      end
    end else if (m_st == 1) begin
      if (sh_err) begin
        m_st = 0; m_busy = 0; m_done = 1; m_err = 1;
      end else begin
        m_init = phase; m_wait = 0; m_n = 0; m_st = 2;
      end
    end else begin
      m_wait++;
      if (m_wait == m_int) begin
        m_wait = 0;
        if (sh_err) begin
          m_st = 0; m_busy = 0; m_done = 1; m_err = 1;
        end else begin
          m_mask = m_mask | (phase ^ m_init);
          m_n++;
          if (m_n == NS) begin
            m_st = 0; m_busy = 0; m_done = 1;
            m_pass = (m_mask == ((8'hFF << m_k) & 8'hFF));
          end
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 busy", int'(busy), int'(m_busy));
      chk("R5 done", int'(done), int'(m_done));
      chk("R5 pass", int'(pass), int'(m_pass));
      chk("R6 err",  int'(err),  int'(m_err));
      chk("R4 mask", int'(mask), int'(m_mask));
    end
  end

  task automatic kick(input logic [3:0] k, input logic [15:0] iv);
    @(negedge clk);
    start = 1'b1; ratio = k; intv = iv;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) break;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 mask", int'(mask), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pass after release", int'(pass), 0);

    // R5 matched ratio 16: low 4 bits stable
    smask = 8'h0F; sval = 8'h05;
    kick(4'd4, 16'd3);
    chk("R2 busy after accept", int'(busy), 1);
    wait_done();
    chk("R5 ratio16 pass", int'(pass), 1);
    chk("R5 ratio16 mask", int'(mask), 8'hF0);
    repeat (10) @(negedge clk);
    chk("R7 held pass", int'(pass), 1);
    chk("R7 held mask", int'(mask), 8'hF0);

    // R5 pulse too fast: only 3 bits stable vs ratio 16
    smask = 8'h07; sval = 8'h02;
    kick(4'd4, 16'd3);
    wait_done();
    chk("R5 too-wide mask fails", int'(pass), 0);
    chk("R5 too-wide mask value", int'(mask), 8'hF8);

    // R5 pulse too slow: 5 bits stable vs ratio 4
    smask = 8'h1F; sval = 8'h0A;
    kick(4'd2, 16'd2);
    wait_done();
    chk("R5 too-narrow mask fails", int'(pass), 0);
    chk("R5 too-narrow mask value", int'(mask), 8'hE0);

    // R3 interval 0 acts as 1, ratio 1 expects all bits toggling
    smask = 8'h00;
    kick(4'd0, 16'd0);
    repeat (NS + 1) @(negedge clk);
    chk("R3 zero interval finishes after NS+1 edges", int'(done), 1);
    chk("R3 ratio1 pass", int'(pass), 1);

    // R6 error mid-run, held for a full interval
    smask = 8'h0F; sval = 8'h05;
    kick(4'd4, 16'd4);
    repeat (20) @(negedge clk);
    sh_err = 1'b1;
    repeat (4) @(negedge clk);
    sh_err = 1'b0;
    chk("R6 mid-run err", int'(err), 1);
    chk("R6 mid-run no pass", int'(pass), 0);

    // R6 error on initial reading
    @(negedge clk);
    start = 1'b1; ratio = 4'd4; intv = 16'd3;
    @(negedge clk);
    start = 1'b0; sh_err = 1'b1;
    @(negedge clk);
    sh_err = 1'b0;
    chk("R6 init err", int'(err), 1);
    chk("R6 init err mask", int'(mask), 0);

    // R8 start while busy ignored
    smask = 8'h0F; sval = 8'h05;
    kick(4'd4, 16'd3);
    repeat (5) @(negedge clk);
    start = 1'b1; ratio = 4'd1; intv = 16'd1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 still busy", int'(busy), 1);
    wait_done();
    chk("R8 first ratio kept", int'(pass), 1);
    chk("R8 mask", int'(mask), 8'hF0);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule